// File: doc/BRIEF.md
# Thermal ADC Auto-Monitor Controller

This controller runs a multi-channel temperature-sensor converter without software in the loop. After each waiting period it requests one conversion from every enabled monitoring channel in turn. It stores each 12-bit result and compares it with two per-channel limits: one for interrupts and one for shutdown. The sensor code falls as the temperature rises, so a sample counts as hot when its code is less than or equal to the limit.

Two waiting periods are available. The long one applies while everything is cool. The short one applies as soon as any channel's latest result reaches either of its limits. A hit on the interrupt limit must repeat for a programmed number of consecutive samples before the channel's pending bit is set. The shutdown path works the same way with its own count, but its result stays latched until reset. Each channel's shutdown can be steered to a reset-controller output, to a GPIO output, or to both. Both outputs share a programmable active level.

Channel 0 is reserved. Only channels 1 and above are ever converted. Software reaches the controller through a simple register port with an 8-bit address and 16-bit data; reads are combinational from the address.

Top module: `tmon_ctrl`

## Requirements
- R1: After reset the following hold:
  - The waiting periods read 250 at address 0x68 (normal) and 50 at 0x6C (hot).
  - Both debounce counts read 4, at 0x60 (interrupt) and 0x64 (shutdown).
  - The control register (0x04), routing register (0x08), pending register (0x0C) and all data registers read 0.
  - `irq` and `adc_req` are low, and both shutdown outputs sit at their inactive level: high, because the polarity bit is 0.
- R2: While bit 0 of 0x04 is set, each sweep requests every channel n ≥ 1 whose source bit (4+n) of 0x04 is set, in ascending order. Channel 0 is never requested, even when bit 4 is set. `adc_req` stays high with a stable `adc_chan` until `adc_ready` is seen.
- R3: The data register of channel n, at 0x20+4·n, reads 0 until that channel's first conversion and then holds its latest code.
- R4: The wait between sweeps is the period register times PRESCALE clock cycles. The hot period (0x6C) is used whenever any channel's latest code is ≤ its interrupt limit (0x30+4·n) or ≤ its shutdown limit (0x40+4·n). Otherwise the normal period (0x68) is used.
- R5: A channel's interrupt pending bit n of 0x0C is set once its code has been ≤ its interrupt limit on as many consecutive samples as the count at 0x60. Any sample above the limit restarts the count. `irq` is the OR of all pending bits.
- R6: Bit n of 0x08 enables the interrupt of channel n. A disabled channel never sets its pending bit and never raises `irq`.
- R7: A write to 0x0C with data bit 8 at 0 clears each pending bit whose data bit is 1. A write with bit 8 at 1 leaves the pending bits unchanged.
- R8: A channel whose code has been ≤ its shutdown limit on as many consecutive samples as the count at 0x64 latches a shutdown. The latch is cleared only by reset, and fewer consecutive samples do not latch it.
- R9: A latched shutdown of channel n drives `shut_gpio` active when bit 4+n of 0x08 is set, and drives `shut_rst` active when bit 8+n of 0x08 is set.
- R10: Bit 8 of 0x04 sets the active level of both shutdown outputs: 1 for active high, 0 for active low.
- R11: Clearing bit 0 of 0x04 stops new sweeps once the current sweep has finished. The data registers keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| adc_req | output | 1 | Conversion request, held until ready |
| adc_chan | output | CH_W | Channel being converted |
| adc_ready | input | 1 | One-cycle strobe: `adc_code` is valid |
| adc_code | input | 12 | Converted sensor code |
| irq | output | 1 | Interrupt, OR of the pending bits |
| shut_gpio | output | 1 | Shutdown output towards a GPIO |
| shut_rst | output | 1 | Shutdown output towards the reset controller |

## Verification
A sample taken on the edge where `adc_ready` is high shows up in the data register, in a pending bit and in the shutdown latch right after that same edge. The bench therefore waits until the converter model has delivered a given number of codes, lets one more edge pass, and only then samples `irq`, the shutdown outputs or the registers. Register writes and polarity or routing changes reach the outputs one edge after the write strobe, so those checks sit on the following falling edge. Sweep intervals are measured from request to request on channel 1. The difference between normal and hot operation must equal exactly the period difference times PRESCALE, which removes the fixed sweep length from the check.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int CODE_W = 12;
  localparam int RDW    = 16;

  localparam logic [7:0] A_CTRL  = 8'h04;
  localparam logic [7:0] A_ROUTE = 8'h08;
  localparam logic [7:0] A_PEND  = 8'h0C;
  localparam logic [7:0] A_DATA  = 8'h20;
  localparam logic [7:0] A_ICMP  = 8'h30;
  localparam logic [7:0] A_SCMP  = 8'h40;
  localparam logic [7:0] A_IDEB  = 8'h60;
  localparam logic [7:0] A_SDEB  = 8'h64;
  localparam logic [7:0] A_PNRM  = 8'h68;
  localparam logic [7:0] A_PHOT  = 8'h6C;

  localparam int PNRM_RST = 250;
  localparam int PHOT_RST = 50;
  localparam int DEB_RST  = 4;

  typedef enum logic {ST_WAIT, ST_SCAN} seq_state_t;
endpackage

// File: rtl/tmon_seq.sv
module tmon_seq
  import tmon_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int PRESCALE = 4,
  parameter int PER_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      auto_en,
  input  logic [NUM_CH-1:0]         src_en,
  input  logic [PER_W-1:0]          period_sel,
  input  logic                      adc_ready,
  output logic                      adc_req,
  output logic [$clog2(NUM_CH)-1:0] adc_chan,
  output logic                      smp_vld
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  seq_state_t       st_q, st_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic tick, expire, ch_on, last_ch;

  assign tick    = (pre_q == PRE_W'(PRESCALE - 1));
  assign expire  = tick && (({1'b0, cnt_q} + (PER_W+1)'(1)) >= {1'b0, period_sel});
  assign ch_on   = src_en[ch_q];
  assign last_ch = (ch_q == CH_W'(NUM_CH - 1));

  assign adc_req  = (st_q == ST_SCAN) && ch_on;
  assign adc_chan = ch_q;
  assign smp_vld  = adc_req && adc_ready;

  // next-state: wait with a live-selected limit, then sweep channels 1..NUM_CH-1
  always_comb begin
    st_d  = st_q;
    pre_d = pre_q;
    cnt_d = cnt_q;
    ch_d  = ch_q;
    case (st_q)
      ST_WAIT: begin
        if (!auto_en) begin
          pre_d = '0;
          cnt_d = '0;
        end else if (expire) begin
          st_d  = ST_SCAN;
          ch_d  = CH_W'(1);
          pre_d = '0;
          cnt_d = '0;
        end else begin
          pre_d = tick ? '0 : pre_q + PRE_W'(1);
          if (tick) cnt_d = cnt_q + PER_W'(1);
        end
      end
      default: begin
        if (!ch_on || adc_ready) begin
          if (last_ch) begin
            st_d  = ST_WAIT;
            pre_d = '0;
            cnt_d = '0;
          end else begin
            ch_d = ch_q + CH_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      pre_q <= '0;
      cnt_q <= '0;
      ch_q  <= CH_W'(1);
    end else begin
      st_q  <= st_d;
      pre_q <= pre_d;
      cnt_q <= cnt_d;
      ch_q  <= ch_d;
    end
  end
endmodule

// File: rtl/tmon_chan.sv
module tmon_chan
  import tmon_pkg::*;
#(
  parameter int DEB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp,
  input  logic [CODE_W-1:0] code,
  input  logic              icmp_we,
  input  logic              scmp_we,
  input  logic [CODE_W-1:0] wcode,
  input  logic [DEB_W-1:0]  ideb,
  input  logic [DEB_W-1:0]  sdeb,
  output logic [CODE_W-1:0] data,
  output logic [CODE_W-1:0] icmp,
  output logic [CODE_W-1:0] scmp,
  output logic              hot,
  output logic              int_fire,
  output logic              shut_lat
);
  logic [CODE_W-1:0] data_q, data_d, icmp_q, icmp_d, scmp_q, scmp_d;
  logic              seen_q, seen_d, shut_q, shut_d;
  logic [DEB_W-1:0]  icnt_q, icnt_d, scnt_q, scnt_d;
  logic [DEB_W-1:0]  i_inc, s_inc, ideb_e, sdeb_e;
  logic              i_over, s_over;

  always_comb begin
    i_over = (code <= icmp_q);
    s_over = (code <= scmp_q);
    i_inc  = (&icnt_q) ? icnt_q : icnt_q + DEB_W'(1);
    s_inc  = (&scnt_q) ? scnt_q : scnt_q + DEB_W'(1);
    ideb_e = (ideb == '0) ? DEB_W'(1) : ideb;
    sdeb_e = (sdeb == '0) ? DEB_W'(1) : sdeb;
    data_d = data_q;
    seen_d = seen_q;
    icnt_d = icnt_q;
    scnt_d = scnt_q;
    shut_d = shut_q;
    icmp_d = icmp_we ? wcode : icmp_q;
    scmp_d = scmp_we ? wcode : scmp_q;
    int_fire = 1'b0;
    if (smp) begin
      data_d   = code;
      seen_d   = 1'b1;
      icnt_d   = i_over ? i_inc : '0;
      scnt_d   = s_over ? s_inc : '0;
      int_fire = i_over && (i_inc >= ideb_e);
      if (s_over && (s_inc >= sdeb_e)) shut_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      seen_q <= 1'b0;
      icnt_q <= '0;
      scnt_q <= '0;
      shut_q <= 1'b0;
      icmp_q <= '0;
      scmp_q <= '0;
    end else begin
      data_q <= data_d;
      seen_q <= seen_d;
      icnt_q <= icnt_d;
      scnt_q <= scnt_d;
      shut_q <= shut_d;
      icmp_q <= icmp_d;
      scmp_q <= scmp_d;
    end
  end

  assign data     = data_q;
  assign icmp     = icmp_q;
  assign scmp     = scmp_q;
  assign shut_lat = shut_q;
  assign hot      = seen_q && ((data_q <= icmp_q) || (data_q <= scmp_q));
endmodule

// File: rtl/tmon_ctrl.sv
module tmon_ctrl
  import tmon_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int PRESCALE = 4,
  parameter int PER_W    = 16,
  parameter int DEB_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [7:0]                reg_addr,
  input  logic [RDW-1:0]            reg_wdata,
  output logic [RDW-1:0]            reg_rdata,
  output logic                      adc_req,
  output logic [$clog2(NUM_CH)-1:0] adc_chan,
  input  logic                      adc_ready,
  input  logic [CODE_W-1:0]         adc_code,
  output logic                      irq,
  output logic                      shut_gpio,
  output logic                      shut_rst
);
  localparam int CH_W = $clog2(NUM_CH);

  logic              auto_q, auto_d, pol_q, pol_d;
  logic [NUM_CH-1:0] src_q, src_d, ien_q, ien_d, gpio_q, gpio_d, rstr_q, rstr_d;
  logic [NUM_CH-1:0] pend_q, pend_d, clr, fire, hot, shut;
  logic [DEB_W-1:0]  ideb_q, ideb_d, sdeb_q, sdeb_d;
  logic [PER_W-1:0]  pnrm_q, pnrm_d, phot_q, phot_d;
  logic [CODE_W-1:0] data_a [NUM_CH];
  logic [CODE_W-1:0] icmp_a [NUM_CH];
  logic [CODE_W-1:0] scmp_a [NUM_CH];
  logic              smp_vld, gpio_act, rst_act;

  tmon_seq #(.NUM_CH(NUM_CH), .PRESCALE(PRESCALE), .PER_W(PER_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_q), .src_en(src_q),
    .period_sel((|hot) ? phot_q : pnrm_q), .adc_ready(adc_ready),
    .adc_req(adc_req), .adc_chan(adc_chan), .smp_vld(smp_vld)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmon_chan #(.DEB_W(DEB_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .smp(smp_vld && (adc_chan == CH_W'(g))), .code(adc_code),
      .icmp_we(reg_we && (reg_addr == A_ICMP + 8'(4*g))),
      .scmp_we(reg_we && (reg_addr == A_SCMP + 8'(4*g))),
      .wcode(reg_wdata[CODE_W-1:0]), .ideb(ideb_q), .sdeb(sdeb_q),
      .data(data_a[g]), .icmp(icmp_a[g]), .scmp(scmp_a[g]),
      .hot(hot[g]), .int_fire(fire[g]), .shut_lat(shut[g])
    );
  end

  // register file next state
  always_comb begin
    auto_d = auto_q; pol_d = pol_q; src_d = src_q;
    ien_d = ien_q; gpio_d = gpio_q; rstr_d = rstr_q;
    ideb_d = ideb_q; sdeb_d = sdeb_q; pnrm_d = pnrm_q; phot_d = phot_q;
    clr = '0;
    if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          auto_d = reg_wdata[0];
          src_d  = reg_wdata[4 +: NUM_CH];
          pol_d  = reg_wdata[8];
        end
        A_ROUTE: begin
          ien_d  = reg_wdata[0 +: NUM_CH];
          gpio_d = reg_wdata[4 +: NUM_CH];
          rstr_d = reg_wdata[8 +: NUM_CH];
        end
        A_PEND:  if (!reg_wdata[8]) clr = reg_wdata[NUM_CH-1:0];
        A_IDEB:  ideb_d = reg_wdata[DEB_W-1:0];
        A_SDEB:  sdeb_d = reg_wdata[DEB_W-1:0];
        A_PNRM:  pnrm_d = reg_wdata[PER_W-1:0];
        A_PHOT:  phot_d = reg_wdata[PER_W-1:0];
        default: ;
      endcase
    end
    pend_d = (pend_q & ~clr) | (fire & ien_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0; pol_q <= 1'b0; src_q <= '0;
      ien_q <= '0; gpio_q <= '0; rstr_q <= '0; pend_q <= '0;
      ideb_q <= DEB_W'(DEB_RST); sdeb_q <= DEB_W'(DEB_RST);
      pnrm_q <= PER_W'(PNRM_RST); phot_q <= PER_W'(PHOT_RST);
    end else begin
      auto_q <= auto_d; pol_q <= pol_d; src_q <= src_d;
      ien_q <= ien_d; gpio_q <= gpio_d; rstr_q <= rstr_d; pend_q <= pend_d;
      ideb_q <= ideb_d; sdeb_q <= sdeb_d;
      pnrm_q <= pnrm_d; phot_q <= phot_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]            = auto_q;
        reg_rdata[4 +: NUM_CH]  = src_q;
        reg_rdata[8]            = pol_q;
      end
      A_ROUTE: begin
        reg_rdata[0 +: NUM_CH]  = ien_q;
        reg_rdata[4 +: NUM_CH]  = gpio_q;
        reg_rdata[8 +: NUM_CH]  = rstr_q;
      end
      A_PEND:  reg_rdata[NUM_CH-1:0] = pend_q;
      A_IDEB:  reg_rdata[DEB_W-1:0]  = ideb_q;
      A_SDEB:  reg_rdata[DEB_W-1:0]  = sdeb_q;
      A_PNRM:  reg_rdata[PER_W-1:0]  = pnrm_q;
      A_PHOT:  reg_rdata[PER_W-1:0]  = phot_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == A_DATA + 8'(4*i)) reg_rdata[CODE_W-1:0] = data_a[i];
      if (reg_addr == A_ICMP + 8'(4*i)) reg_rdata[CODE_W-1:0] = icmp_a[i];
      if (reg_addr == A_SCMP + 8'(4*i)) reg_rdata[CODE_W-1:0] = scmp_a[i];
    end
  end

  assign irq       = |pend_q;
  assign gpio_act  = |(shut & gpio_q);
  assign rst_act   = |(shut & rstr_q);
  assign shut_gpio = pol_q ? gpio_act : ~gpio_act;
  assign shut_rst  = pol_q ? rst_act : ~rst_act;
endmodule

// File: rtl/tmon_chk.sv
module tmon_chk #(
  parameter int CH_W   = 2,
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_req,
  input logic              adc_ready,
  input logic [CH_W-1:0]   adc_chan,
  input logic              irq,
  input logic              shut_gpio,
  input logic              pol,
  input logic [NUM_CH-1:0] gpio_route,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic              wdata8
);
  // R2: reserved channel 0 is never requested
  assert_no_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |-> (adc_chan != '0));

  // R2: request and channel held until ready
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ready) |=> (adc_req && $stable(adc_chan)));

  // R5: interrupt only rises right after a delivered sample
  assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(adc_ready));

  // R7: interrupt only drops after a clearing write to the pending register
  assert_irq_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_we && (reg_addr == 8'h0C) && !wdata8));

  // R8: an active GPIO shutdown stays active while polarity and routing hold
  assert_shut_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_gpio == pol) |=> ((shut_gpio == pol) || !$stable(pol) || !$stable(gpio_route)));
endmodule

bind tmon_ctrl tmon_chk #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_req(adc_req), .adc_ready(adc_ready),
  .adc_chan(adc_chan), .irq(irq), .shut_gpio(shut_gpio), .pol(pol_q),
  .gpio_route(gpio_q), .reg_we(reg_we), .reg_addr(reg_addr), .wdata8(reg_wdata[8])
);

// File: tb/tb_tmon_ctrl.sv
`timescale 1ns/1ps
module tb_tmon_ctrl;
  logic        clk, rst_n, reg_we, adc_ready, irq, shut_gpio, shut_rst, adc_req;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, rv;
  logic [1:0]  adc_chan;
  logic [11:0] adc_code;
  logic [11:0] code_ch [3];
  int errors = 0, checks = 0, cyc = 0, req_total = 0;
  int conv_cnt [3];
  int exp_q [$];
  int cur = 0, lat = 0, ch1_prev = 0, ch1_int = 0, n_int = 0, t0 = 0;
  bit busy = 0, have_prev = 0, done = 0;

  tmon_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_req(adc_req),
    .adc_chan(adc_chan), .adc_ready(adc_ready), .adc_code(adc_code),
    .irq(irq), .shut_gpio(shut_gpio), .shut_rst(shut_rst)
  );

  initial clk = 0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver side of the scoreboard: expected channel order of requests
  task automatic push_sweeps(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(1);
      exp_q.push_back(2);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_conv(input int ch, input int n);
    int tgt;
    tgt = conv_cnt[ch] + n;
    while (conv_cnt[ch] < tgt) @(posedge clk);
    @(negedge clk);
  endtask

  // converter model and monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      adc_ready = 0; busy = 0;
    end else if (adc_ready) begin
      adc_ready = 0; busy = 0;
    end else if (busy) begin
      if (lat == 0) begin
        adc_ready = 1; adc_code = code_ch[cur]; conv_cnt[cur]++;
      end else lat--;
    end else if (adc_req) begin
      cur = int'(adc_chan);
      req_total++;
      if (exp_q.size() == 0) check("R2 unexpected request", cur, -1);
      else check("R2 channel order", cur, exp_q.pop_front());
      if (cur == 1) begin
        if (have_prev) ch1_int = cyc - ch1_prev;
        ch1_prev = cyc; have_prev = 1;
      end
      busy = 1; lat = 2;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; adc_ready = 0; adc_code = 0;
    code_ch[0] = 12'd3500; code_ch[1] = 12'd3000; code_ch[2] = 12'd3100;
    for (int i = 0; i < 3; i++) conv_cnt[i] = 0;
    push_sweeps(100);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 shut_gpio idle", shut_gpio, 1);
    check("R1 shut_rst idle", shut_rst, 1);
    check("R1 adc_req", adc_req, 0);
    rd(8'h68, rv); check("R1 normal period", rv, 250);
    rd(8'h6C, rv); check("R1 hot period", rv, 50);
    rd(8'h60, rv); check("R1 int debounce", rv, 4);
    rd(8'h64, rv); check("R1 shut debounce", rv, 4);
    rd(8'h04, rv); check("R1 control", rv, 0);
    rd(8'h0C, rv); check("R1 pending", rv, 0);

    wr(8'h68, 16'd20);
    wr(8'h6C, 16'd5);
    wr(8'h34, 16'd2000);
    wr(8'h38, 16'd2000);
    wr(8'h48, 16'd1500);
    wr(8'h08, 16'h0042);
    wr(8'h04, 16'h0071);
    rd(8'h24, rv); check("R3 data before first conversion", rv, 0);

    wait_conv(1, 1);
    rd(8'h24, rv); check("R3 data ch1", rv, 3000);
    wait_conv(2, 1);
    rd(8'h28, rv); check("R3 data ch2", rv, 3100);
    wait_conv(1, 2);
    n_int = ch1_int;

    // R5: three hot samples, one cool, then four hot
    code_ch[1] = 12'd1900;
    wait_conv(1, 3); check("R5 three hot samples", irq, 0);
    code_ch[1] = 12'd3000;
    wait_conv(1, 1); check("R5 count restarts", irq, 0);
    code_ch[1] = 12'd1900;
    wait_conv(1, 3); check("R5 three after restart", irq, 0);
    wait_conv(1, 1); check("R5 fourth hot sample", irq, 1);
    check("R4 hot period shortens sweep interval", n_int - ch1_int, 60);

    // R7: clearing the pending bit
    code_ch[1] = 12'd3000;
    wr(8'h0C, 16'h0102);
    check("R7 write with bit 8 set", irq, 1);
    rd(8'h0C, rv); check("R7 pending kept", rv, 2);
    wr(8'h0C, 16'h0002);
    check("R7 clear", irq, 0);
    rd(8'h0C, rv); check("R7 pending cleared", rv, 0);

    // R6: channel 2 hot on its interrupt limit but not enabled
    code_ch[2] = 12'd1900;
    wait_conv(2, 5);
    check("R6 disabled channel irq", irq, 0);
    rd(8'h0C, rv); check("R6 disabled channel pending", rv, 0);

    // R8/R9: shutdown on channel 2, routed to GPIO only
    code_ch[2] = 12'd1400;
    wait_conv(2, 3); check("R8 three samples no shutdown", shut_gpio, 1);
    wait_conv(2, 1); check("R8 shutdown active low", shut_gpio, 0);
    check("R9 not routed to reset", shut_rst, 1);
    code_ch[2] = 12'd3100;
    wait_conv(2, 2); check("R8 shutdown latched", shut_gpio, 0);

    // R10: polarity
    wr(8'h04, 16'h0171);
    check("R10 gpio active high", shut_gpio, 1);
    check("R10 reset idle low", shut_rst, 0);
    wr(8'h08, 16'h0442);
    check("R9 routed to reset", shut_rst, 1);

    // R11: stop automatic mode
    wr(8'h04, 16'h0170);
    repeat (200) @(negedge clk);
    t0 = req_total;
    repeat (400) @(negedge clk);
    check("R11 no new requests", req_total, t0);
    rd(8'h28, rv); check("R11 ch2 data kept", rv, 3100);
    rd(8'h24, rv); check("R11 ch1 data kept", rv, 3000);

    done = 1;
    repeat (4) @(negedge clk);
    report();
  end
endmodule